// File: doc/BRIEF.md
# SPI Slave Register-Access Controller

This block is the serial front end of a peripheral that is reached over SPI. While the slave select is active, the first byte of each frame is a command. Its top bit says whether the frame reads or writes, and its low three bits give a starting register address. Every byte after that is a data byte. Each data byte goes to or comes from the addressed register, and the address then steps up by one, wrapping inside an eight-entry window. All logic runs on rising edges of the SPI clock. Input bits are sampled MSB first, and output bits are presented MSB first ahead of the edge that consumes them.

Two addresses have side effects. A completed write to the data-low address asks a transmit queue to take a byte. A completed write to the control address raises an abort request. Any completed access to the data-low address while the receive queue holds data asks that queue to pop. Each of these requests is a pulse one clock long. Completed writes are also presented on a write port, so that the register file behind the block can latch them. The queues, the register storage and any crossing into a system clock domain belong to the surrounding logic.

Top module: `spi_reg_access`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) puts the block in idle and clears every strobe and `wr_en`. In idle, `sdo` is 0.
- R2: When `sel_n` is high at a rising edge, the block returns to idle, clears the write flag and discards any partial byte. The next frame starts again with a command byte.
- R3: The first bit sampled after `sel_n` goes low is the direction flag (1 = write, 0 = read). The command byte has 8 bits, MSB first, and its bits 2..0 set the starting register address.
- R4: Every byte, command or data, takes exactly 8 rising edges. The bit position falls by one on each edge that is not the last of the byte.
- R5: After each completed data byte the register address increments by one, and address 7 wraps to 0.
- R6: In a write frame, one cycle after the last edge of each data byte, `wr_en` is high for one cycle with `wr_addr` set to the byte's address and `wr_data` set to the received byte.
- R7: A completed write byte to address 7 (control) pulses `abort_req` at the same cycle as its `wr_en`.
- R8: A completed write byte to address 0 (data-low) pulses `tx_push` at the same cycle as its `wr_en`.
- R9: A completed byte at address 0, read or write, pulses `rx_pop` if `rx_not_empty` was high at its last edge. If it was low, there is no pulse.
- R10: During a data byte, `sdo` carries the current register's `reg_view` entry MSB first, each bit valid before the edge that ends it. During the command byte, `sdo` is 0.
- R11: Every strobe lasts exactly one clock. A byte cut short by `sel_n` going high produces no strobe and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| spi_clk | input | 1 | SPI clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| reg_view | input | 64 | Eight 8-bit register values, entry i at bits [8i+7:8i] |
| rx_not_empty | input | 1 | Receive queue holds at least one entry |
| tx_push | output | 1 | Transmit-queue push pulse |
| rx_pop | output | 1 | Receive-queue pop pulse |
| abort_req | output | 1 | Abort pulse |
| wr_en | output | 1 | Register write pulse |
| wr_addr | output | 3 | Address of the written register |
| wr_data | output | 8 | Byte written |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 3-bit address, data-low at 0 and control at 7. Because the two side-effect addresses sit on either side of the wrap point, a single burst can reach both strobes and the 7-to-0 rollover. A nine-byte write starting at address 7 visits control twice and data-low once. Read frames run with the receive queue both empty and non-empty, and one frame is cut off in the middle of a data-low write byte to show that partial bytes have no effect.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_BURST = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic tx_push;
        logic rx_pop;
        logic abort;
        logic wr_en;
    } strobe_t;

    localparam strobe_t STROBE_NONE = '{tx_push: 1'b0, rx_pop: 1'b0, abort: 1'b0, wr_en: 1'b0};

    function automatic logic addr_hit(input logic [7:0] ptr, input int unsigned target);
        return ptr == 8'(target);
    endfunction

endpackage

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_active,
    input  logic                 sdi,
    output frame_state_e         state,
    output logic                 wr_flag,
    output logic [DATA_W-1:0]    byte_in,
    output logic                 cmd_done,
    output logic                 byte_done
);
    localparam int BPW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BPW-1:0] BIT_TOP = BPW'(DATA_W - 1);

    logic [BPW-1:0]    bit_ptr;
    logic [DATA_W-1:0] in_sh;
    logic              last_bit;

    assign last_bit  = (bit_ptr == '0);
    assign byte_in   = {in_sh[DATA_W-2:0], sdi};
    assign cmd_done  = sel_active && (state == ST_CMD) && last_bit;
    assign byte_done = sel_active && (state == ST_BURST) && last_bit;

    always_ff @(posedge clk) begin
        if (rst || !sel_active) begin
            state   <= ST_IDLE;
            bit_ptr <= BIT_TOP;
            wr_flag <= 1'b0;
            in_sh   <= '0;
        end else begin
            in_sh <= byte_in;
            unique case (state)
                ST_IDLE: begin
                    state   <= ST_CMD;
                    wr_flag <= sdi;
                    bit_ptr <= BIT_TOP - BPW'(1);
                end
                ST_CMD: begin
                    if (last_bit) begin
                        bit_ptr <= BIT_TOP;
                        state   <= ST_BURST;
                    end else begin
                        bit_ptr <= bit_ptr - BPW'(1);
                    end
                end
                ST_BURST: begin
                    bit_ptr <= last_bit ? BIT_TOP : bit_ptr - BPW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    idle_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sel_active) |=> (state == ST_CMD && wr_flag == $past(sdi)));

    // R4
    bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_active && state != ST_IDLE && !last_bit) |=> (bit_ptr == $past(bit_ptr) - BPW'(1)));

    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_active) |=> (state == ST_IDLE && bit_ptr == BIT_TOP && !wr_flag));

endmodule

// File: rtl/spi_reg_pointer.sv
module spi_reg_pointer
    import spi_reg_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 3,
    parameter int DATA_LO_ADDR = 0,
    parameter int CTRL_ADDR    = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_done,
    input  logic               byte_done,
    input  logic               wr_flag,
    input  logic [DATA_W-1:0]  byte_in,
    input  logic               rx_not_empty,
    output logic [ADDR_W-1:0]  next_ptr,
    output strobe_t            strb,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data
);
    logic [ADDR_W-1:0] reg_ptr;
    logic              at_data_lo;
    logic              at_ctrl;

    assign next_ptr   = cmd_done ? byte_in[ADDR_W-1:0] : reg_ptr + ADDR_W'(1);
    assign at_data_lo = addr_hit(8'(reg_ptr), DATA_LO_ADDR);
    assign at_ctrl    = addr_hit(8'(reg_ptr), CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_ptr <= '0;
        end else if (cmd_done || byte_done) begin
            reg_ptr <= next_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb    <= STROBE_NONE;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            strb.wr_en   <= byte_done && wr_flag;
            strb.tx_push <= byte_done && wr_flag && at_data_lo;
            strb.abort   <= byte_done && wr_flag && at_ctrl;
            strb.rx_pop  <= byte_done && at_data_lo && rx_not_empty;
            if (byte_done) begin
                wr_addr <= reg_ptr;
                wr_data <= byte_in;
            end
        end
    end

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> (reg_ptr == $past(reg_ptr) + ADDR_W'(1)));

    // R7
    abort_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        strb.abort |-> (strb.wr_en && wr_addr == ADDR_W'(CTRL_ADDR)));

    // R8
    push_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        strb.tx_push |-> (strb.wr_en && wr_addr == ADDR_W'(DATA_LO_ADDR)));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.tx_push || strb.rx_pop || strb.abort || strb.wr_en) |=>
        !(strb.tx_push || strb.rx_pop || strb.abort || strb.wr_en));

endmodule

// File: rtl/spi_sdo_shifter.sv
module spi_sdo_shifter
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_active,
    input  frame_state_e       state,
    input  logic               load,
    input  logic [DATA_W-1:0]  load_data,
    output logic               sdo
);
    logic [DATA_W-1:0] out_sh;

    always_ff @(posedge clk) begin
        if (rst || !sel_active) begin
            out_sh <= '0;
        end else if (load) begin
            out_sh <= load_data;
        end else if (state == ST_BURST) begin
            out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
    end

    assign sdo = (state == ST_BURST) ? out_sh[DATA_W-1] : 1'b0;

    // R10
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (load && sel_active) |=> (out_sh == $past(load_data)));

endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
    import spi_reg_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 3,
    parameter int DATA_LO_ADDR = 0,
    parameter int CTRL_ADDR    = 7,
    localparam int NREG        = 1 << ADDR_W
) (
    input  logic                    spi_clk,
    input  logic                    rst,
    input  logic                    sel_n,
    input  logic                    sdi,
    output logic                    sdo,
    input  logic [NREG*DATA_W-1:0]  reg_view,
    input  logic                    rx_not_empty,
    output logic                    tx_push,
    output logic                    rx_pop,
    output logic                    abort_req,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]       wr_data
);
    frame_state_e      state;
    logic              sel_active;
    logic              wr_flag;
    logic [DATA_W-1:0] byte_in;
    logic              cmd_done;
    logic              byte_done;
    logic [ADDR_W-1:0] next_ptr;
    logic [DATA_W-1:0] load_data;
    strobe_t           strb;

    assign sel_active = !sel_n;
    assign load_data  = reg_view[next_ptr*DATA_W +: DATA_W];

    spi_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (spi_clk),
        .rst        (rst),
        .sel_active (sel_active),
        .sdi        (sdi),
        .state      (state),
        .wr_flag    (wr_flag),
        .byte_in    (byte_in),
        .cmd_done   (cmd_done),
        .byte_done  (byte_done)
    );

    spi_reg_pointer #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .DATA_LO_ADDR (DATA_LO_ADDR),
        .CTRL_ADDR    (CTRL_ADDR)
    ) u_ptr (
        .clk          (spi_clk),
        .rst          (rst),
        .cmd_done     (cmd_done),
        .byte_done    (byte_done),
        .wr_flag      (wr_flag),
        .byte_in      (byte_in),
        .rx_not_empty (rx_not_empty),
        .next_ptr     (next_ptr),
        .strb         (strb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    spi_sdo_shifter #(.DATA_W(DATA_W)) u_sdo (
        .clk        (spi_clk),
        .rst        (rst),
        .sel_active (sel_active),
        .state      (state),
        .load       (cmd_done || byte_done),
        .load_data  (load_data),
        .sdo        (sdo)
    );

    assign tx_push   = strb.tx_push;
    assign rx_pop    = strb.rx_pop;
    assign abort_req = strb.abort;
    assign wr_en     = strb.wr_en;

    // R1
    reset_quiet_chk: assert property (@(posedge spi_clk)
        rst |=> !(tx_push || rx_pop || abort_req || wr_en || sdo));

endmodule

// File: tb/spi_reg_access_tb_top.sv
module spi_reg_access_tb_top;

    logic        spi_clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [63:0] reg_view;
    logic        rx_not_empty = 1'b0;
    logic        tx_push, rx_pop, abort_req, wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;

    int errors = 0;
    int checks = 0;
    int n_wr = 0, n_tx = 0, n_pop = 0, n_abort = 0;
    logic [2:0] wa_log [0:31];
    logic [7:0] wd_log [0:31];

    always #4 spi_clk = ~spi_clk;

    spi_reg_access dut_i (
        .spi_clk      (spi_clk),
        .rst          (rst),
        .sel_n        (sel_n),
        .sdi          (sdi),
        .sdo          (sdo),
        .reg_view     (reg_view),
        .rx_not_empty (rx_not_empty),
        .tx_push      (tx_push),
        .rx_pop       (rx_pop),
        .abort_req    (abort_req),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    function automatic logic [7:0] reg_val(input int i);
        return 8'h3C ^ 8'(i * 8'h27);
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) reg_view[i*8 +: 8] = reg_val(i);
    end

    always @(negedge spi_clk) begin
        if (wr_en && n_wr < 32) begin
            wa_log[n_wr] = wr_addr;
            wd_log[n_wr] = wr_data;
        end
        if (wr_en)     n_wr++;
        if (tx_push)   n_tx++;
        if (rx_pop)    n_pop++;
        if (abort_req) n_abort++;
    end

    task automatic check(input int actual, input int expected, input string tag);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic shift_byte(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge spi_clk);
            sel_n = 1'b0;
            sdi   = tx[i];
            rx[i] = sdo;
        end
    endtask

    task automatic end_frame();
        @(negedge spi_clk);
        sel_n = 1'b1;
        sdi   = 1'b0;
        repeat (3) @(negedge spi_clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge spi_clk);
        rst = 1'b0;
        @(negedge spi_clk);
        check(int'(sdo), 0, "R1 sdo after reset");
        check(int'({tx_push, rx_pop, abort_req, wr_en}), 0, "R1 strobes after reset");
    endtask

    task automatic t_write_burst();
        logic [7:0] rx;
        logic [7:0] dat [0:3];
        int b_wr, b_tx, b_pop, b_ab;
        dat[0] = 8'hA5; dat[1] = 8'h5A; dat[2] = 8'hC3; dat[3] = 8'h81;
        b_wr = n_wr; b_tx = n_tx; b_pop = n_pop; b_ab = n_abort;
        rx_not_empty = 1'b1;
        shift_byte(8'h86, rx, 8);
        check(int'(rx), 0, "R10 sdo low during command");
        for (int k = 0; k < 4; k++) shift_byte(dat[k], rx, 8);
        end_frame();
        check(n_wr - b_wr, 4, "R6 write count");
        for (int k = 0; k < 4; k++) begin
            check(int'(wa_log[b_wr+k]), (6 + k) % 8, "R3 R5 R6 write address");
            check(int'(wd_log[b_wr+k]), int'(dat[k]), "R6 write data");
        end
        check(n_ab_diff(b_ab), 1, "R7 abort on control write");
        check(n_tx - b_tx, 1, "R8 push on data-low write");
        check(n_pop - b_pop, 1, "R9 pop on data-low write with data");
        rx_not_empty = 1'b0;
    endtask

    function automatic int n_ab_diff(input int base);
        return n_abort - base;
    endfunction

    task automatic t_read_wrap_empty();
        logic [7:0] rx;
        int b_wr, b_tx, b_pop, b_ab;
        b_wr = n_wr; b_tx = n_tx; b_pop = n_pop; b_ab = n_abort;
        rx_not_empty = 1'b0;
        shift_byte(8'h07, rx, 8);
        check(int'(rx), 0, "R10 sdo low during read command");
        shift_byte(8'hFF, rx, 8);
        check(int'(rx), int'(reg_val(7)), "R10 read address 7");
        shift_byte(8'hFF, rx, 8);
        check(int'(rx), int'(reg_val(0)), "R5 R10 read wraps to 0");
        shift_byte(8'h00, rx, 8);
        check(int'(rx), int'(reg_val(1)), "R10 read address 1");
        end_frame();
        check(n_wr - b_wr, 0, "R6 no write in read frame");
        check(n_ab_diff(b_ab) + n_tx - b_tx, 0, "R7 R8 no abort or push in read frame");
        check(n_pop - b_pop, 0, "R9 no pop when queue empty");
    endtask

    task automatic t_read_pop();
        logic [7:0] rx;
        int b_tx, b_pop;
        b_tx = n_tx; b_pop = n_pop;
        rx_not_empty = 1'b1;
        shift_byte(8'h00, rx, 8);
        shift_byte(8'h00, rx, 8);
        check(int'(rx), int'(reg_val(0)), "R10 read address 0");
        shift_byte(8'h00, rx, 8);
        check(int'(rx), int'(reg_val(1)), "R4 R10 read address 1");
        end_frame();
        check(n_pop - b_pop, 1, "R9 pop on data-low read");
        check(n_tx - b_tx, 0, "R8 no push on read");
        rx_not_empty = 1'b0;
    endtask

    task automatic t_cut_short();
        logic [7:0] rx;
        int b_wr, b_tx, b_pop;
        b_wr = n_wr; b_tx = n_tx; b_pop = n_pop;
        rx_not_empty = 1'b1;
        shift_byte(8'h80, rx, 8);
        shift_byte(8'hFF, rx, 5);
        end_frame();
        check(n_wr - b_wr, 0, "R11 no write on cut byte");
        check(n_tx - b_tx, 0, "R11 no push on cut byte");
        check(n_pop - b_pop, 0, "R11 no pop on cut byte");
        rx_not_empty = 1'b0;
        shift_byte(8'h02, rx, 8);
        shift_byte(8'h00, rx, 8);
        end_frame();
        check(int'(rx), int'(reg_val(2)), "R2 fresh frame after deselect");
    endtask

    task automatic t_long_wrap();
        logic [7:0] rx;
        int b_wr, b_tx, b_ab;
        b_wr = n_wr; b_tx = n_tx; b_ab = n_abort;
        shift_byte(8'hFF, rx, 8);
        for (int k = 0; k < 9; k++) shift_byte(8'(8'h10 + k), rx, 8);
        end_frame();
        check(n_wr - b_wr, 9, "R5 nine writes");
        check(int'(wa_log[b_wr+8]), 7, "R5 second lap reaches 7");
        check(int'(wd_log[b_wr+1]), 8'h11, "R6 data after wrap");
        check(n_ab_diff(b_ab), 2, "R7 two aborts over full lap");
        check(n_tx - b_tx, 1, "R8 one push over full lap");
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_write_burst();
        t_read_wrap_empty();
        t_read_pop();
        t_cut_short();
        t_long_wrap();
        rst = 1'b1;
        @(negedge spi_clk);
        rst = 1'b0;
        @(negedge spi_clk);
        check(int'({tx_push, rx_pop, abort_req, wr_en, sdo}), 0, "R1 quiet after final reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule